// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block holds a parameterised set of event counters that software programs through a small register window. One index register picks a counter. The per-counter registers then act on that counter: its running value, its interrupt threshold and its condition select. The running value and the threshold are each split into a low 32-bit word and a high word. On each clock cycle, a counter adds one when three things hold at once. The global run bit is set. The event input picked by its condition select is high. Its processor-mode qualifiers accept the current mode. A counter whose next value equals its threshold raises a sticky interrupt-active flag. The flags that are also enabled drive one interrupt line.

Software reads a running counter through a snapshot pair. Setting the snapshot bit in the control word copies the whole value of the selected counter in one cycle, so the low and high words always belong together. Condition code 0 never counts, and this is how one counter is stopped while the others keep running. The interrupt-active flags are cleared by writing 1 to them. That write also drops the enable of the same counter, so a handler must re-enable each counter it has serviced.

The register port takes at most one access per cycle and never stalls. Writes take effect at the clock edge. Reads are combinational from the address. The block has no streaming data path, so it has no valid/ready pair and no back-pressure.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset the index, the control word, every count, threshold and condition, the interrupt-active and interrupt-enable masks and `irq_o` are all zero.
- R2: The index register (address 0x0, bits [7:0]) selects one counter. Count-low (0x2), count-high (0x3), threshold-low (0x6), threshold-high (0x7) and condition (0x8) act only on that counter.
- R3: Writing the control word (0x1) with bit 1 set copies the selected counter's value, as it stood before that edge, into the snapshot pair: low word at 0x4, high word at 0x5. The pair holds that value while the counter keeps running. Bit 1 always reads back as 0.
- R4: Control bit 0 is the global run bit. While it is 0, no counter changes except through a count write. Bits [31:16] of the control word read 0 and are never changed by a write.
- R5: A condition select (condition bits [7:0]) of 0, or of more than NUM_EVT, never counts. A value k from 1 to NUM_EVT counts the cycles in which `evt_i[k-1]` is high.
- R6: Condition bit 8 (kernel only) blocks counting while `user_mode_i` is 1. Condition bit 9 (user only) blocks counting while `user_mode_i` is 0.
- R7: A counter that increments to a value equal to its threshold sets its bit in the interrupt-active mask (0xA). A set bit stays set until it is cleared. `irq_o` is high while any active bit has its bit set in the enable mask (0x9).
- R8: Writing 1 to a bit of 0xA clears that active bit and the same bit of the enable mask. Bits written as 0 change nothing.
- R9: The build register (0xB) reads as follows: bit 0 is 1 (counters present), bit 1 is HAS_IRQ, bits [15:8] are NUM_CNT and bits [19:16] are SIZE_CODE.
- R10: A write to count-low or count-high loads that word of the selected counter and leaves the other word alone. It overrides an increment in the same cycle.
- R11: An index of NUM_CNT or more selects no counter. Per-counter reads then return 0 and per-counter writes change nothing. The index itself reads back as written.
- R12: The counter is 32 + 16*SIZE_CODE bits wide (SIZE_CODE 1 or 2). A carry out of the low word reaches the high word, and all ones wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event inputs, one per countable condition |
| user_mode_i | input | 1 | 1 while the processor runs in user mode, 0 in kernel mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Shared counter interrupt |

## Verification
Some properties are checked on every cycle. The run bit freezes all counts. A stopped condition freezes its own counter. No counter moves by more than one unless it is being loaded. Active flags fall only under a write-one clear, and that clear drops the matching enable bit. Other behaviour can only be shown by the bench scenarios. These are which event and mode each counter follows, and whether the snapshot captures the value from before the edge. They also cover the cycle on which the threshold flag appears, load priority over an increment, carry and wrap across the two words, and the ignored out-of-range index.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned SEL_W  = 8;

  localparam logic [ADDR_W-1:0] A_INDEX  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h3;
  localparam logic [ADDR_W-1:0] A_SNP_LO = 4'h4;
  localparam logic [ADDR_W-1:0] A_SNP_HI = 4'h5;
  localparam logic [ADDR_W-1:0] A_THR_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_THR_HI = 4'h7;
  localparam logic [ADDR_W-1:0] A_COND   = 4'h8;
  localparam logic [ADDR_W-1:0] A_IRQ_EN = 4'h9;
  localparam logic [ADDR_W-1:0] A_IRQ_ACT= 4'hA;
  localparam logic [ADDR_W-1:0] A_BUILD  = 4'hB;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_SNAP_BIT = 1;
  localparam int unsigned COND_KERN_BIT = 8;
  localparam int unsigned COND_USER_BIT = 9;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned CNT_W   = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               user_mode_i,
  input  logic [31:0]        wdata_i,
  input  logic               ld_lo_i,
  input  logic               ld_hi_i,
  input  logic               thr_lo_i,
  input  logic               thr_hi_i,
  input  logic               cond_wr_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   thr_o,
  output logic [31:0]        cond_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               hit_o
);
  localparam int unsigned HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, thr_q, cnt_nxt;
  logic [SEL_W-1:0] sel_q;
  logic             kern_q, user_q;
  logic             ev, mode_ok, inc, load;

  // event picked by the condition select; 0 and out-of-range codes never fire
  always_comb begin
    ev = 1'b0;
    for (int k = 1; k <= NUM_EVT; k++) begin
      if (sel_q == SEL_W'(k)) ev = evt_i[k-1];
    end
  end

  assign mode_ok = !(kern_q && user_mode_i) && !(user_q && !user_mode_i);
  assign inc     = run_i && ev && mode_ok;
  assign load    = ld_lo_i || ld_hi_i;
  assign cnt_nxt = cnt_q + 1'b1;
  assign hit_o   = inc && !load && (cnt_nxt == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_lo_i) begin
      cnt_q <= {cnt_q[CNT_W-1:32], wdata_i};
    end else if (ld_hi_i) begin
      cnt_q <= {HI_W'(wdata_i), cnt_q[31:0]};
    end else if (inc) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_lo_i) begin
      thr_q <= {thr_q[CNT_W-1:32], wdata_i};
    end else if (thr_hi_i) begin
      thr_q <= {HI_W'(wdata_i), thr_q[31:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      kern_q <= 1'b0;
      user_q <= 1'b0;
    end else if (cond_wr_i) begin
      sel_q  <= wdata_i[SEL_W-1:0];
      kern_q <= wdata_i[COND_KERN_BIT];
      user_q <= wdata_i[COND_USER_BIT];
    end
  end

  always_comb begin
    cond_o                = '0;
    cond_o[SEL_W-1:0]     = sel_q;
    cond_o[COND_KERN_BIT] = kern_q;
    cond_o[COND_USER_BIT] = user_q;
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/pcb_irq.sv
module pcb_irq #(
  parameter int unsigned NUM_CNT = 4,
  parameter bit          HAS_IRQ = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] hit_i,
  input  logic               en_wr_i,
  input  logic               clr_wr_i,
  input  logic [NUM_CNT-1:0] wmask_i,
  output logic [NUM_CNT-1:0] act_o,
  output logic [NUM_CNT-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] act_q, en_q, clr;

  assign clr = clr_wr_i ? wmask_i : '0;

  // a fresh hit in the clearing cycle survives the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      en_q  <= '0;
    end else begin
      act_q <= (act_q & ~clr) | hit_i;
      if (en_wr_i) en_q <= wmask_i;
      else         en_q <= en_q & ~clr;
    end
  end

  generate
    if (HAS_IRQ) begin : g_line
      assign irq_o = |(act_q & en_q);
    end else begin : g_no_line
      assign irq_o = 1'b0;
    end
  endgenerate

  assign act_o = act_q;
  assign en_o  = en_q;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_CNT   = 4,
  parameter int unsigned NUM_EVT   = 8,
  parameter int unsigned SIZE_CODE = 1,
  parameter bit          HAS_IRQ   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               user_mode_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int unsigned CNT_W = 32 + 16 * SIZE_CODE;

  logic [IDX_W-1:0]                idx_q;
  logic                            run_q;
  logic [CNT_W-1:0]                snap_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all, thr_all;
  logic [NUM_CNT-1:0][31:0]        cond_all;
  logic [NUM_CNT-1:0][SEL_W-1:0]   sel_all;
  logic [NUM_CNT-1:0]              hit, act, en, pick;
  logic [CNT_W-1:0]                cnt_s, thr_s;
  logic [31:0]                     cond_s, build_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      run_q  <= 1'b0;
      snap_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_INDEX) idx_q <= wdata_i[IDX_W-1:0];
      if (addr_i == A_CTRL) begin
        run_q <= wdata_i[CTRL_RUN_BIT];
        if (wdata_i[CTRL_SNAP_BIT]) snap_q <= cnt_s;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      assign pick[g] = (idx_q == IDX_W'(g));
      pcb_counter #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_q),
        .evt_i       (evt_i),
        .user_mode_i (user_mode_i),
        .wdata_i     (wdata_i),
        .ld_lo_i     (wr_en_i && pick[g] && addr_i == A_CNT_LO),
        .ld_hi_i     (wr_en_i && pick[g] && addr_i == A_CNT_HI),
        .thr_lo_i    (wr_en_i && pick[g] && addr_i == A_THR_LO),
        .thr_hi_i    (wr_en_i && pick[g] && addr_i == A_THR_HI),
        .cond_wr_i   (wr_en_i && pick[g] && addr_i == A_COND),
        .cnt_o       (cnt_all[g]),
        .thr_o       (thr_all[g]),
        .cond_o      (cond_all[g]),
        .sel_o       (sel_all[g]),
        .hit_o       (hit[g])
      );
    end
  endgenerate

  // selected-counter view; an out-of-range index matches nothing and reads 0
  always_comb begin
    cnt_s  = '0;
    thr_s  = '0;
    cond_s = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (pick[k]) begin
        cnt_s  = cnt_all[k];
        thr_s  = thr_all[k];
        cond_s = cond_all[k];
      end
    end
  end

  pcb_irq #(.NUM_CNT(NUM_CNT), .HAS_IRQ(HAS_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .en_wr_i  (wr_en_i && addr_i == A_IRQ_EN),
    .clr_wr_i (wr_en_i && addr_i == A_IRQ_ACT),
    .wmask_i  (wdata_i[NUM_CNT-1:0]),
    .act_o    (act),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  always_comb begin
    build_w        = '0;
    build_w[0]     = 1'b1;
    build_w[1]     = HAS_IRQ;
    build_w[15:8]  = 8'(NUM_CNT);
    build_w[19:16] = 4'(SIZE_CODE);
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_INDEX:   rdata_o = 32'(idx_q);
      A_CTRL:    rdata_o = {31'b0, run_q};
      A_CNT_LO:  rdata_o = cnt_s[31:0];
      A_CNT_HI:  rdata_o = 32'(cnt_s >> 32);
      A_SNP_LO:  rdata_o = snap_q[31:0];
      A_SNP_HI:  rdata_o = 32'(snap_q >> 32);
      A_THR_LO:  rdata_o = thr_s[31:0];
      A_THR_HI:  rdata_o = 32'(thr_s >> 32);
      A_COND:    rdata_o = cond_s;
      A_IRQ_EN:  rdata_o = 32'(en);
      A_IRQ_ACT: rdata_o = 32'(act);
      A_BUILD:   rdata_o = build_w;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          run,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [31:0]                   wdata,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CNT-1:0][SEL_W-1:0] sel_all,
  input logic [NUM_CNT-1:0]            act,
  input logic [NUM_CNT-1:0]            en
);
  logic               ld;
  logic               clr_wr;
  logic [NUM_CNT-1:0] clr;

  assign ld     = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
  assign clr_wr = wr_en && (addr == A_IRQ_ACT);
  assign clr    = clr_wr ? wdata[NUM_CNT-1:0] : '0;

  // R4: halted bank holds every count unless a count word is written
  a_r4_global_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt_all));

  // R7: an active flag only falls under a write-one clear of its bit
  a_r7_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~act & $past(act) & ~$past(clr)) == '0));

  // R8: a write-one clear also drops the matching enable bits
  a_r8_clear_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (clr != '0)) |=> ((en & $past(clr)) == '0));

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
      // R12: without a load a counter moves by zero or one (wrap included)
      a_r12_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt_all[g] == $past(cnt_all[g]) ||
                 cnt_all[g] == $past(cnt_all[g]) + 1'b1));
      // R5: condition code 0 never counts
      a_r5_never: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_all[g] == '0 && !ld) |=> $stable(cnt_all[g]));
    end
  endgenerate
endmodule

bind perf_counter_bank pcb_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_pcb_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .wr_en   (wr_en_i),
  .addr    (addr_i),
  .wdata   (wdata_i),
  .cnt_all (cnt_all),
  .sel_all (sel_all),
  .act     (act),
  .en      (en)
);

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;
  localparam int NC = 4;
  localparam int NE = 8;
  localparam int SC = 1;
  localparam logic [31:0] HI_MASK = (SC == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic          user_mode_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [3:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  perf_counter_bank #(.NUM_CNT(NC), .NUM_EVT(NE), .SIZE_CODE(SC), .HAS_IRQ(1'b1)) u_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .user_mode_i(user_mode_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; evt_i = '0; user_mode_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit counts(input logic [31:0] cond, input bit user, input logic [NE-1:0] ev);
    int s = int'(cond[7:0]);
    if (s == 0 || s > NE) return 1'b0;
    if (cond[8] && user) return 1'b0;
    if (cond[9] && !user) return 1'b0;
    return ev[s-1];
  endfunction

  logic [31:0] m_lo [NC];
  logic [31:0] m_hi [NC];
  logic [31:0] m_cond [NC];

  function automatic void m_inc(input int k);
    if (m_lo[k] == 32'hFFFF_FFFF) m_hi[k] = (m_hi[k] + 1) & HI_MASK;
    m_lo[k] = m_lo[k] + 1;
  endfunction

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rchk("R1 index", 4'h0, 32'h0);
    rchk("R1 ctrl", 4'h1, 32'h0);
    rchk("R1 count lo", 4'h2, 32'h0);
    rchk("R1 cond", 4'h8, 32'h0);
    rchk("R1 active", 4'hA, 32'h0);
    rchk("R1 enable", 4'h9, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R9 build word
    rchk("R9 build", 4'hB, 32'h0001_0403);

    // R2 index routing
    for (int k = 0; k < NC; k++) begin
      wr(4'h0, k); wr(4'h2, 32'h100 + k); wr(4'h3, k + 1);
    end
    for (int k = 0; k < NC; k++) begin
      wr(4'h0, k);
      rchk("R2 count lo", 4'h2, 32'h100 + k);
      rchk("R2 count hi", 4'h3, k + 1);
    end

    // R11 out-of-range index
    wr(4'h0, NC);
    rchk("R11 index readback", 4'h0, NC);
    wr(4'h2, 32'h55); wr(4'h8, 32'h1);
    rchk("R11 count reads 0", 4'h2, 32'h0);
    rchk("R11 cond reads 0", 4'h8, 32'h0);
    wr(4'h0, NC - 1);
    rchk("R11 write ignored", 4'h2, 32'h100 + NC - 1);
    rchk("R11 cond unchanged", 4'h8, 32'h0);

    // R4 control word
    wr(4'h1, 32'hFFFF_0000);
    rchk("R4 upper bits", 4'h1, 32'h0);
    evt_i = '1;
    repeat (4) @(negedge clk);
    rchk("R4 halted count", 4'h2, 32'h100 + NC - 1);
    evt_i = '0;

    // R3 snapshot before the edge, held while running
    do_reset();
    wr(4'h2, 32'd50); wr(4'h8, 32'h1);
    evt_i = '1;
    wr(4'h1, 32'h3);
    rchk("R3 snap bit reads 0", 4'h1, 32'h1);
    repeat (4) @(negedge clk);
    rchk("R3 snapshot lo", 4'h4, 32'd50);
    rchk("R3 snapshot hi", 4'h5, 32'd0);
    rchk("R3 count kept running", 4'h2, 32'd54);

    // R10 load beats increment
    wr(4'h2, 32'd100);
    wr(4'h1, 32'h0);
    rchk("R10 load priority", 4'h2, 32'd101);
    wr(4'h3, 32'h7);
    rchk("R10 hi load keeps lo", 4'h2, 32'd101);
    rchk("R10 hi load", 4'h3, 32'h7);
    evt_i = '0;

    // R5, R6 qualifiers and never
    do_reset();
    wr(4'h0, 0); wr(4'h8, 32'h101);
    wr(4'h0, 1); wr(4'h8, 32'h201);
    wr(4'h0, 2); wr(4'h8, 32'h1);
    wr(4'h0, 3); wr(4'h8, 32'h0);
    wr(4'h1, 32'h1);
    evt_i = '1; user_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    user_mode_i = 1'b0;
    repeat (5) @(negedge clk);
    evt_i = '0;
    wr(4'h1, 32'h0);
    wr(4'h0, 0); rchk("R6 kernel only", 4'h2, 32'd5);
    wr(4'h0, 1); rchk("R6 user only", 4'h2, 32'd3);
    wr(4'h0, 2); rchk("R6 no qualifier", 4'h2, 32'd8);
    wr(4'h0, 3); rchk("R5 never code", 4'h2, 32'd0);
    wr(4'h8, NE + 1); wr(4'h1, 32'h1);
    evt_i = '1; repeat (3) @(negedge clk); evt_i = '0;
    wr(4'h1, 32'h0);
    rchk("R5 out-of-range code", 4'h2, 32'd0);

    // R7, R8 threshold flag, line, write-one clear
    do_reset();
    for (int k = 0; k < 2; k++) begin
      wr(4'h0, k); wr(4'h2, 32'd7); wr(4'h6, 32'd10); wr(4'h8, 32'h1);
    end
    wr(4'h9, 32'h2);
    evt_i = 8'h01;
    wr(4'h1, 32'h1);
    repeat (2) @(negedge clk);
    rchk("R7 not yet active", 4'hA, 32'h0);
    chk("R7 irq low", 32'(irq_o), 32'h0);
    @(negedge clk);
    evt_i = '0;
    rchk("R7 active at threshold", 4'hA, 32'h3);
    chk("R7 irq high", 32'(irq_o), 32'h1);
    wr(4'hA, 32'h0);
    rchk("R8 zero write no effect", 4'hA, 32'h3);
    wr(4'hA, 32'h2);
    rchk("R8 active cleared", 4'hA, 32'h1);
    rchk("R8 enable cleared", 4'h9, 32'h0);
    chk("R8 irq dropped", 32'(irq_o), 32'h0);
    wr(4'h1, 32'h0);

    // R12 carry and wrap (threshold left at 0 flags the wrap)
    do_reset();
    wr(4'h0, 2); wr(4'h2, 32'hFFFF_FFFE); wr(4'h8, 32'h1);
    wr(4'h1, 32'h1);
    evt_i = '1; repeat (2) @(negedge clk); evt_i = '0;
    rchk("R12 carry lo", 4'h2, 32'h0);
    rchk("R12 carry hi", 4'h3, 32'h1);
    wr(4'h2, 32'hFFFF_FFFF); wr(4'h3, HI_MASK);
    evt_i = '1; @(negedge clk); evt_i = '0;
    rchk("R12 wrap lo", 4'h2, 32'h0);
    rchk("R12 wrap hi", 4'h3, 32'h0);
    rchk("R7 wrap reaches zero threshold", 4'hA, 32'h4);
    wr(4'h1, 32'h0);

    // random rounds: R5, R6 conditions checked through the snapshot (R3)
    void'($urandom(32'd2024));
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int k = 0; k < NC; k++) begin
        m_lo[k] = $urandom; m_hi[k] = 0;
        m_cond[k] = ($urandom % (NE + 2)) | (($urandom % 4) << 8);
        wr(4'h0, k); wr(4'h2, m_lo[k]); wr(4'h8, m_cond[k]);
        wr(4'h6, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF);
      end
      wr(4'h1, 32'h1);
      for (int c = 0; c < 64; c++) begin
        evt_i = NE'($urandom); user_mode_i = 1'($urandom);
        for (int k = 0; k < NC; k++)
          if (counts(m_cond[k], user_mode_i, evt_i)) m_inc(k);
        @(negedge clk);
      end
      evt_i = '0;
      for (int k = 0; k < NC; k++) begin
        wr(4'h0, k); wr(4'h1, 32'h3);
        rchk($sformatf("R6 random lo c%0d", k), 4'h4, m_lo[k]);
        rchk($sformatf("R12 random hi c%0d", k), 4'h5, m_hi[k]);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule